// File: doc/BRIEF.md
# Clocked-Memory Replacement for a 512 x 8 Asynchronous Static RAM

This block lets a board design drop its 512 x 8 asynchronous static RAM and use synchronous on-chip block memory instead. The host side sees the familiar pins: a 9-bit address, active-low select, write strobe and output strobe, and an 8-bit bidirectional data bus. Inside, the active-low strobes become active-high memory controls. The write strobe is gated by select, and the memory output is returned to the shared bus through a tristate driver.

The memory samples address, write data and write strobe on every rising edge of its own clock. That clock runs at twice the host system clock. A read or a write therefore completes well inside one host cycle, and the part looks asynchronous to the host. Contents are zero at configuration. A write followed at once by a read of the same word returns the new data.

Top module: `sram_emu`

## Requirements
- R1: The storage holds 512 independent 8-bit words selected by one 9-bit address; address 0, 256 and 511 hold distinct values at the same time.
- R2: A word is written only in a clk_i cycle where cs_ni = 0 and we_ni = 0; with cs_ni = 1 a low we_ni leaves every stored word unchanged.
- R3: When cs_ni = 0, oe_ni = 0 and we_ni = 1, data_io carries the word stored at addr_i.
- R4: In every other combination of cs_ni, oe_ni and we_ni the block releases data_io to high impedance, and the release takes effect without waiting for a clock edge.
- R5: The data written in one clk_i cycle is already the read result after that edge (write-first), so a read of the same address immediately after a write returns the new value.
- R6: Before any write, every word reads as 0x00.
- R7: A new address is sampled on the next rising edge of clk_i; until that edge data_io keeps the previous read result, and after it the word at the new address appears.
- R8: While rst_ni = 0 the read register holds 0x00 and writes are ignored; stored words survive the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Memory clock, twice the host system clock |
| rst_ni | input | 1 | Asynchronous active-low reset of the read register |
| addr_i | input | 9 | Word address from the host |
| cs_ni | input | 1 | Chip select, active low |
| we_ni | input | 1 | Write strobe, active low |
| oe_ni | input | 1 | Output strobe, active low |
| data_io | inout | 8 | Shared bidirectional data bus |

## Verification
The assertions assume that the host changes pins only between clk_i edges. They also assume that a clk_i cycle with both cs_ni and we_ni low is meant as a write, since the block cannot tell a strobe that is settling from a real write. The bench changes every pin on the falling edge of clk_i and holds it for two clk_i cycles, which is one host cycle. It drives the bus itself only while its write strobe is low. A pull-up on the bus makes a released bus read 0xFF, and the bench never stores 0xFF, so an unwanted drive from the block shows up as a wrong value.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  localparam int unsigned ADDR_W_DEF = 9;
  localparam int unsigned DATA_W_DEF = 8;

  typedef struct packed {
    logic en;   // memory port enabled this cycle
    logic wr;   // gated write
    logic drv;  // bus driver on
  } mem_ctrl_t;
endpackage

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
  import sram_emu_pkg::*;
(
  input  logic      cs_ni,
  input  logic      we_ni,
  input  logic      oe_ni,
  output mem_ctrl_t ctrl_o
);
  logic cs, we, oe;

  // active-low pins to active-high memory controls
  assign cs = ~cs_ni;
  assign we = ~we_ni;
  assign oe = ~oe_ni;

  always_comb begin
    ctrl_o.en  = cs;
    ctrl_o.wr  = cs & we;
    ctrl_o.drv = cs & oe & ~we;
  end
endmodule

// File: rtl/sram_emu_mem.sv
module sram_emu_mem #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              past_ok_q;

  // configuration-time contents
  initial begin
    for (int i = 0; i < DEPTH; i++) mem_q[i] = '0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_ni && en_i && we_i) mem_q[addr_i] <= wdata_i;
  end

  // write-first read register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
    end else if (en_i) begin
      if (we_i) rdata_o <= wdata_i;
      else      rdata_o <= mem_q[addr_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  AST_WRITE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i) |=> (rdata_o == $past(wdata_i))); // R5

  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && en_i && !we_i && $past(en_i) && !$past(we_i) && $stable(addr_i))
    |=> $stable(rdata_o)); // R7
endmodule

// File: rtl/sram_emu.sv
module sram_emu
  import sram_emu_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  inout  wire  [DATA_W-1:0] data_io
);
  mem_ctrl_t         ctrl;
  logic [DATA_W-1:0] rdata;

  sram_emu_ctrl u_ctrl (
    .cs_ni  (cs_ni),
    .we_ni  (we_ni),
    .oe_ni  (oe_ni),
    .ctrl_o (ctrl)
  );

  // write data straight from the bus pins
  sram_emu_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl.en),
    .we_i    (ctrl.wr),
    .addr_i  (addr_i),
    .wdata_i (data_io),
    .rdata_o (rdata)
  );

  assign data_io = ctrl.drv ? rdata : {DATA_W{1'bz}};

  AST_WRITE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl.wr |-> (!cs_ni && !we_ni)); // R2

  AST_BUS_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || oe_ni || !we_ni) |-> !ctrl.drv); // R4

  AST_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !oe_ni && we_ni) |-> ctrl.drv); // R3
endmodule

// File: tb/sram_emu_tb.sv
module sram_emu_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] addr = '0;
  logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic       tb_oe = 1'b0;
  logic [7:0] tb_d = '0;
  wire  [7:0] bus;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;
  logic [7:0] ref_mem [512];

  always #4 clk = ~clk;

  assign bus = tb_oe ? tb_d : 8'bz;
  for (genvar g = 0; g < 8; g++) begin : g_pu
    pullup (bus[g]);
  end

  sram_emu u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .cs_ni   (cs_n),
    .we_ni   (we_n),
    .oe_ni   (oe_n),
    .data_io (bus)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  // one host cycle = two clk cycles; sample at its end
  task automatic host(input logic [8:0] a, input logic c, input logic w, input logic o,
                      input logic [7:0] d, input string req);
    logic [7:0] exp;
    @(negedge clk);
    addr = a; cs_n = c; we_n = w; oe_n = o; tb_d = d; tb_oe = !w;
    @(negedge clk);
    @(negedge clk);
    if (!c && !o && w) exp = rst_n ? ref_mem[a] : 8'h00;
    else if (!w)       exp = d;
    else               exp = 8'hFF;
    chk(bus === exp, req, bus, exp);
    if (!c && !w && rst_n) ref_mem[a] = d;
  endtask

  task automatic idle();
    host(9'd0, 1'b1, 1'b1, 1'b1, 8'h00, "R4");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 00 expected 01");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // reset state: bus released
    chk(bus === 8'hFF, "R4 reset", bus, 8'hFF);
    rst_n = 1'b1;

    // R6: zero before any write
    host(9'd0,   0, 1, 0, 8'h00, "R6");
    host(9'd300, 0, 1, 0, 8'h00, "R6");
    host(9'd511, 0, 1, 0, 8'h00, "R6");

    // R1: full address range, no aliasing
    host(9'd0,   0, 0, 1, 8'hA5, "R1 wr");
    host(9'd256, 0, 0, 1, 8'h3C, "R1 wr");
    host(9'd511, 0, 0, 1, 8'h5A, "R1 wr");
    host(9'd0,   0, 1, 0, 8'h00, "R1");
    host(9'd256, 0, 1, 0, 8'h00, "R1");
    host(9'd511, 0, 1, 0, 8'h00, "R1");

    // R2: deselected write strobe changes nothing
    host(9'd256, 1, 0, 0, 8'h11, "R2 drive");
    host(9'd256, 0, 1, 0, 8'h00, "R2");

    // R4: released for each non-read combination
    host(9'd0, 1, 1, 0, 8'h00, "R4 cs high");
    host(9'd0, 0, 1, 1, 8'h00, "R4 oe high");
    host(9'd0, 0, 0, 0, 8'h42, "R4 we low");
    host(9'd0, 0, 1, 0, 8'h00, "R3");

    // R5: write then read same word at once
    host(9'd77, 0, 0, 1, 8'h9E, "R5 wr");
    @(negedge clk);
    tb_oe = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    #1 chk(bus === 8'h9E, "R5", bus, 8'h9E);
    @(negedge clk); @(negedge clk);
    chk(bus === 8'h9E, "R5", bus, 8'h9E);

    // R7: address takes effect at next clk edge
    host(9'd256, 0, 1, 0, 8'h00, "R7");
    @(negedge clk);
    addr = 9'd511;
    #1 chk(bus === 8'h3C, "R7 before edge", bus, 8'h3C);
    @(negedge clk);
    chk(bus === 8'h5A, "R7 after edge", bus, 8'h5A);

    // R4: release without a clock edge
    oe_n = 1'b1;
    #1 chk(bus === 8'hFF, "R4 async", bus, 8'hFF);

    // R8: reset holds zero, blocks writes, keeps contents
    host(9'd5, 0, 0, 1, 8'h3C, "R8 wr");
    idle();
    @(negedge clk); rst_n = 1'b0;
    host(9'd5, 0, 0, 1, 8'h77, "R8 wr in reset");
    host(9'd5, 0, 1, 0, 8'h00, "R8 read in reset");
    @(negedge clk); rst_n = 1'b1;
    host(9'd5, 0, 1, 0, 8'h00, "R8 survive");

    // mixed traffic on a small window, all combinations (R2 R3 R4)
    lfsr = 32'h1D2C3B4A;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      host({5'd0, lfsr[3:0]}, lfsr[4] & lfsr[5], lfsr[6], lfsr[7],
           lfsr[15:8] & 8'hFE, "R3 mix");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule